// File: doc/BRIEF.md
# Byte-Lane Gated Word Memory

This block is a 16-bit-wide on-chip memory made of two independent 8-bit lanes. It sits behind a processor-style bus that has an active-low chip select, an active-low read strobe and an active-low write strobe. Two bus signals choose the lanes a cycle touches: an active-low upper-byte enable and bit 0 of the byte address. A cycle can touch the lower lane, the upper lane, both lanes, or neither.

Each lane gets its own gated read strobe and its own gated write strobe. A byte write therefore changes only the byte it names, and the other half of the word keeps its value. The word index is taken from the byte-address bits above bit 0. A processor that reaches a word at an odd address issues two byte cycles, and the memory handles them with no extra logic: the first cycle writes the upper lane of one word and the second writes the lower lane of the next word.

Read data is registered. A read cycle loads the selected lanes into the output register and loads zero into the half of any lane it does not select. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `byte_lane_mem`

## Requirements
- R1: While chip select is low, a cycle with address bit 0 low enables the lower lane, which holds data bits [7:0].
- R2: While chip select is low, a cycle with the upper-byte enable low enables the upper lane, which holds data bits [15:8].
- R3: When address bit 0 and the upper-byte enable are both low, the cycle is a full 16-bit access to both lanes.
- R4: The word index is byte-address bits [ADDR_W-1:1]. Byte addresses 2k and 2k+1 reach the same word, and bit 0 never selects a different word.
- R5: While chip select is high, no lane is written and the read-data register holds its value, whatever the strobes are doing.
- R6: A byte write leaves the other byte of the word unchanged. If word 0x1B2C has 0x3D written to its lower lane, it then reads 0x1B3D.
- R7: A word at an odd byte address, written as two consecutive byte cycles, changes only the upper lane of the first word and the lower lane of the next word.
- R8: A cycle with address bit 0 high and the upper-byte enable high selects no lane, modifies no storage, and when it is a read returns 0x0000.
- R9: Data is written on the rising edge at which chip select, the write strobe and the lane enable are all active. Read data appears on rdata after the rising edge at which chip select and the read strobe are low. An unselected lane gives zero on its half.
- R10: While reset is asserted, rdata is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates happen on its rising edge |
| arst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| cs_n | input | 1 | Active-low chip select, shared by both lanes |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bhe_n | input | 1 | Active-low upper-byte enable |
| addr | input | ADDR_W | Byte address; bit 0 selects the lane, the upper bits give the word index |
| wdata | input | 16 | Write data; bits [15:8] go to the upper lane and bits [7:0] to the lower lane |
| rdata | output | 16 | Registered read data; zero in the half of any lane that is not selected |

## Verification
A fault in the lane decode shows up at the ports as the wrong byte changing. The damage stays hidden until that word is read back, so every byte write in the bench is followed by a full-word read of the same word, and one cycle later rdata exposes a lower or upper half that should have kept its value. A fault in the index path, such as bit 0 leaking into the word index, shows up when the two byte addresses of one word return different data. A fault in the read-steering register shows up one cycle after the faulty read as a non-zero unselected half, or as a changed rdata after a cycle with chip select high.

// File: rtl/byte_lane_pkg.sv
package byte_lane_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int LANE_LO = 0;
  localparam int LANE_HI = 1;

  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/bl_rst_sync.sv
module bl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/bl_lane_decode.sv
module bl_lane_decode
  import byte_lane_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       a0,
  input  logic       bhe_n,
  output lane_mask_t wr_gate,
  output lane_mask_t rd_gate,
  output logic       rd_cycle
);
  lane_mask_t sel;

  always_comb begin
    sel          = '0;
    sel[LANE_LO] = ~a0;
    sel[LANE_HI] = ~bhe_n;
  end

  always_comb begin
    rd_cycle = ~cs_n & ~rd_n;
    wr_gate  = sel & {LANES{~cs_n & ~wr_n}};
    rd_gate  = sel & {LANES{rd_cycle}};
  end
endmodule

// File: rtl/bl_lane_store.sv
module bl_lane_store #(
  parameter int IDX_W = 10,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);
  localparam int DEPTH = 1 << IDX_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= din;
  end

  always_comb begin
    dout = mem[idx];
  end
endmodule

// File: rtl/bl_read_steer.sv
module bl_read_steer
  import byte_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cycle,
  input  lane_mask_t        rd_gate,
  input  logic [DATA_W-1:0] lane_q,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_cycle) begin
      for (int i = 0; i < LANES; i++) begin
        rdata_d[i*LANE_W +: LANE_W] = rd_gate[i] ? lane_q[i*LANE_W +: LANE_W] : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R9: an unselected lower lane reads back as zero
  p_lo_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cycle && !rd_gate[LANE_LO]) |=> (rdata[LANE_W-1:0] == '0));
  // R9: an unselected upper lane reads back as zero
  p_hi_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cycle && !rd_gate[LANE_HI]) |=> (rdata[DATA_W-1:LANE_W] == '0));
  // R5: with no read cycle the output holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cycle |=> $stable(rdata));
endmodule

// File: rtl/byte_lane_mem.sv
module byte_lane_mem
  import byte_lane_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              bhe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = ADDR_W - 1;

  logic              rst_n;
  lane_mask_t        wr_gate;
  lane_mask_t        rd_gate;
  logic              rd_cycle;
  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] lane_q;

  assign word_idx = addr[ADDR_W-1:1];

  bl_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  bl_lane_decode u_dec (
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .a0       (addr[0]),
    .bhe_n    (bhe_n),
    .wr_gate  (wr_gate),
    .rd_gate  (rd_gate),
    .rd_cycle (rd_cycle)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bl_lane_store #(.IDX_W(IDX_W), .W(LANE_W)) u_store (
      .clk  (clk),
      .we   (wr_gate[g]),
      .idx  (word_idx),
      .din  (wdata[g*LANE_W +: LANE_W]),
      .dout (lane_q[g*LANE_W +: LANE_W])
    );
  end

  bl_read_steer u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_cycle (rd_cycle),
    .rd_gate  (rd_gate),
    .lane_q   (lane_q),
    .rdata    (rdata)
  );

  // R1: a low address bit 0 during a selected write enables the lower lane
  p_lo_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && !addr[0]) |-> wr_gate[LANE_LO]);
  // R2: a low upper-byte enable during a selected write enables the upper lane
  p_hi_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && !bhe_n) |-> wr_gate[LANE_HI]);
  // R8: an odd address with the upper-byte enable high selects nothing
  p_no_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[0] && bhe_n) |-> (wr_gate == '0 && rd_gate == '0));
  // R5: with chip select high no lane strobe is active
  p_cs_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (wr_gate == '0 && !rd_cycle));
endmodule

// File: tb/byte_lane_mem_test.sv
module byte_lane_mem_test;
  localparam int ADDR_W = 11;

  logic              clk;
  logic              arst_n;
  logic              cs_n, rd_n, wr_n, bhe_n;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       wdata;
  logic [15:0]       rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  byte_lane_mem #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .arst_n(arst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bhe_n(bhe_n), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // fields: [44] write, [43] bhe_n, [42:32] addr, [31:16] wdata, [15:0] expected read
  localparam int NV = 22;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 1'b0, 11'h000, 16'h1234, 16'h0000}, // R3 full write word 0
    {1'b1, 1'b0, 11'h006, 16'h1B2C, 16'h0000}, // R3 full write word 3
    {1'b0, 1'b0, 11'h006, 16'h0000, 16'h1B2C}, // R3 full read
    {1'b1, 1'b1, 11'h006, 16'hFF3D, 16'h0000}, // R1 lower byte only
    {1'b0, 1'b0, 11'h006, 16'h0000, 16'h1B3D}, // R6 upper kept
    {1'b1, 1'b0, 11'h007, 16'h5AEE, 16'h0000}, // R2 upper byte only
    {1'b0, 1'b0, 11'h006, 16'h0000, 16'h5A3D}, // R6 lower kept
    {1'b0, 1'b0, 11'h007, 16'h0000, 16'h5A00}, // R9 upper-only read, R4 alias
    {1'b0, 1'b1, 11'h006, 16'h0000, 16'h003D}, // R9 lower-only read
    {1'b1, 1'b1, 11'h007, 16'hFFFF, 16'h0000}, // R8 no lane write
    {1'b0, 1'b0, 11'h006, 16'h0000, 16'h5A3D}, // R8 word untouched
    {1'b0, 1'b1, 11'h007, 16'h0000, 16'h0000}, // R8 no lane read gives zero
    {1'b1, 1'b0, 11'h008, 16'hAAAA, 16'h0000}, // R7 setup word 4
    {1'b1, 1'b0, 11'h00A, 16'hBBBB, 16'h0000}, // R7 setup word 5
    {1'b1, 1'b0, 11'h009, 16'h77EE, 16'h0000}, // R7 odd word, first byte
    {1'b1, 1'b1, 11'h00A, 16'hEE88, 16'h0000}, // R7 odd word, second byte
    {1'b0, 1'b0, 11'h008, 16'h0000, 16'h77AA}, // R7 word 4
    {1'b0, 1'b0, 11'h00A, 16'h0000, 16'hBB88}, // R7 word 5
    {1'b1, 1'b0, 11'h7FE, 16'hC0DE, 16'h0000}, // R4 top word
    {1'b0, 1'b0, 11'h7FF, 16'h0000, 16'hC000}, // R4 top word, odd address
    {1'b0, 1'b0, 11'h000, 16'h0000, 16'h1234}, // R4 word 0 not aliased
    {1'b0, 1'b0, 11'h006, 16'h0000, 16'h5A3D}  // R4 word 3 intact
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1; rd_n = 1; wr_n = 1; bhe_n = 1; addr = '0; wdata = '0;
  endtask

  task automatic bus_cycle(input bit cs, input bit wr, input bit bhe,
                           input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_n = ~cs; wr_n = ~wr; rd_n = wr; bhe_n = bhe; addr = a; wdata = d;
    @(posedge clk);
    #2;
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    arst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R10", rdata, 16'h0000);
    @(negedge clk) arst_n = 1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      bus_cycle(1'b1, VEC[i][44], VEC[i][43], VEC[i][42:32], VEC[i][31:16]);
      if (!VEC[i][44]) check($sformatf("R9 vec%0d", i), rdata, VEC[i][15:0]);
    end

    // R5: chip select high, strobes active: no write
    bus_cycle(1'b0, 1'b1, 1'b0, 11'h006, 16'hDEAD);
    bus_cycle(1'b1, 1'b0, 1'b0, 11'h006, 16'h0000);
    check("R5 write blocked", rdata, 16'h5A3D);
    // R5: chip select high read leaves rdata unchanged
    bus_cycle(1'b0, 1'b0, 1'b0, 11'h000, 16'h0000);
    check("R5 read blocked", rdata, 16'h5A3D);

    // R10: reset mid-run clears rdata
    @(negedge clk) arst_n = 0;
    #2;
    check("R10 async", rdata, 16'h0000);
    @(negedge clk) arst_n = 1;
    repeat (3) @(posedge clk);
    bus_cycle(1'b1, 1'b0, 1'b0, 11'h008, 16'h0000);
    check("R3 after reset", rdata, 16'h77AA);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule